// File: doc/BRIEF.md
# Profiling Record Filter and Buffer Writer

This block sits at the end of a sampling profiler. Each completed sample record arrives as a single-cycle strobe. The record carries operation-type flags, an event vector, a total latency and a payload word. The block tests the record against three filters: a type filter, an event-mask filter and a latency floor. A record that fails any filter is dropped and leaves no trace. A record that passes is written as one word into a circular buffer, starting at a configured base address.

The level interrupt is raised when a write lands on the configured limit address. While the interrupt is pending, records that pass the filters are not written. Instead, a saturating overflow counter counts them. The interrupt acknowledge stands in for software draining the buffer. It clears the interrupt and sends the next write back to the base address.

Top module: `prof_rec_writer`

## Requirements
- R1: The type filter has three enables: loads only, stores only and branches only. A record passes if it carries the flag of any enabled type. When no enable is set, every record passes, including a record that has no type flag.
- R2: The event filter can only act on these event-vector bit positions: 1 (operation retired), 3 (L1 data refill), 5 (TLB refill), 7 (branch mispredict) and 11 (misaligned access). A record passes if every mask bit set at one of these positions is also set in its event vector. Mask bits at any other position are ignored, so a zero mask passes every record.
- R3: A record passes the latency filter when its total latency is greater than or equal to the minimum threshold. A record whose latency is below the threshold is discarded.
- R4: A discarded record produces no memory write. It does not move the write pointer and does not change the overflow count.
- R5: A kept record written while no interrupt is pending drives `mem_we_o` high for exactly one cycle, in the cycle after the strobe. In that cycle `mem_addr_o` equals base + n, where n is the number of words written since reset or the last acknowledge, and `mem_data_o` equals the payload.
- R6: When a write lands on the limit address, `irq_o` rises in the same cycle as that write. It stays high until it is acknowledged.
- R7: While `irq_o` is high, kept records are not written. Each one instead increments the overflow count by one, and the count saturates at its maximum value.
- R8: `irq_ack_i` clears `irq_o` in the next cycle and sends the next write to the base address. A record in the acknowledge cycle is judged against the interrupt state from before the acknowledge.
- R9: After reset, `mem_we_o`, `irq_o` and the overflow count are zero, and the first write goes to the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record strobe |
| rec_is_load_i | input | 1 | Record is a load |
| rec_is_store_i | input | 1 | Record is a store |
| rec_is_branch_i | input | 1 | Record is a branch |
| rec_events_i | input | EV_W | Event vector |
| rec_latency_i | input | LAT_W | Total latency since sampling began |
| rec_payload_i | input | DATA_W | Word to store |
| cfg_load_en_i | input | 1 | Keep loads |
| cfg_store_en_i | input | 1 | Keep stores |
| cfg_branch_en_i | input | 1 | Keep branches |
| cfg_event_mask_i | input | EV_W | Required event bits |
| cfg_min_latency_i | input | LAT_W | Latency floor |
| cfg_base_i | input | ADDR_W | First buffer word address |
| cfg_limit_i | input | ADDR_W | Last buffer word address |
| irq_ack_i | input | 1 | Interrupt acknowledge / drain |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_data_o | output | DATA_W | Memory write data |
| irq_o | output | 1 | Buffer-full interrupt (level) |
| ovf_count_o | output | OVF_W | Dropped-while-full count |

## Verification
If the write pointer is corrupted, the fault appears at the very next kept record, in the cycle after its strobe, as a wrong `mem_addr_o`. If the pointer is not reset by the acknowledge, the fault appears at the first write after the drain. If a filter decision is wrong, the record's cycle shows either a write that should not happen or a missing one.

A stale or lost interrupt state has two visible effects. It makes writes appear or vanish while the buffer is full. It also makes the overflow count move one cycle after a record that should have been written, or stay still after a record that should have been counted. The bench therefore checks write enable, address, data, interrupt and count in the cycle after every strobe.

// File: rtl/prof_pkg.sv
package prof_pkg;

  localparam int unsigned EV_RETIRED_BIT    = 1;
  localparam int unsigned EV_L1D_REFILL_BIT = 3;
  localparam int unsigned EV_TLB_REFILL_BIT = 5;
  localparam int unsigned EV_MISPRED_BIT    = 7;
  localparam int unsigned EV_MISALIGN_BIT   = 11;
  localparam int unsigned EV_MIN_W          = 12;

  typedef struct packed {
    logic is_branch;
    logic is_store;
    logic is_load;
  } op_type_t;

  function automatic bit is_filterable(int unsigned pos);
    return (pos == EV_RETIRED_BIT)    || (pos == EV_L1D_REFILL_BIT) ||
           (pos == EV_TLB_REFILL_BIT) || (pos == EV_MISPRED_BIT)    ||
           (pos == EV_MISALIGN_BIT);
  endfunction

endpackage

// File: rtl/prof_filter.sv
module prof_filter #(
  parameter int unsigned EV_W  = 16,
  parameter int unsigned LAT_W = 12
) (
  input  logic                  valid_i,
  input  prof_pkg::op_type_t    type_i,
  input  logic [EV_W-1:0]       events_i,
  input  logic [LAT_W-1:0]      latency_i,
  input  prof_pkg::op_type_t    type_en_i,
  input  logic [EV_W-1:0]       event_mask_i,
  input  logic [LAT_W-1:0]      min_latency_i,
  output logic                  keep_o
);

  logic [EV_W-1:0] ev_bit_ok;
  logic            type_ok;
  logic            event_ok;
  logic            lat_ok;

  // Only architected positions can block a record
  for (genvar i = 0; i < EV_W; i++) begin : g_ev
    if (prof_pkg::is_filterable(i)) begin : g_filt
      assign ev_bit_ok[i] = !event_mask_i[i] || events_i[i];
    end else begin : g_free
      assign ev_bit_ok[i] = 1'b1;
    end
  end

  assign type_ok  = (type_en_i == '0) || ((type_en_i & type_i) != '0);
  assign event_ok = &ev_bit_ok;
  assign lat_ok   = latency_i >= min_latency_i;
  assign keep_o   = valid_i && type_ok && event_ok && lat_ok;

endmodule

// File: rtl/prof_sat_counter.sv
module prof_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);

  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         count_o <= '0;
    else if (inc_i && (count_o != MAX))  count_o <= count_o + 1'b1;
  end

  assert_ovf_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/prof_buf_writer.sv
module prof_buf_writer #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              keep_i,
  input  logic [DATA_W-1:0] payload_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              ack_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              irq_o,
  output logic              drop_o
);

  logic [ADDR_W-1:0] off_q;
  logic [ADDR_W-1:0] wr_addr;
  logic              do_write;

  assign wr_addr  = base_i + off_q;
  assign do_write = keep_i && !irq_o;
  assign drop_o   = keep_i && irq_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      off_q      <= '0;
      irq_o      <= 1'b0;
    end else begin
      mem_we_o <= do_write;
      if (do_write) begin
        mem_addr_o <= wr_addr;
        mem_data_o <= payload_i;
        off_q      <= off_q + 1'b1;
        if (wr_addr == limit_i) irq_o <= 1'b1;
      end
      // drain overrides
      if (ack_i) begin
        off_q <= '0;
        irq_o <= 1'b0;
      end
    end
  end

  assert_no_write_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !mem_we_o);

  assert_irq_on_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (mem_we_o && (mem_addr_o == limit_i)));

  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o);

  assert_addr_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((mem_addr_o >= base_i) && (mem_addr_o <= limit_i)));

endmodule

// File: rtl/prof_rec_writer.sv
module prof_rec_writer #(
  parameter int unsigned EV_W   = 16,
  parameter int unsigned LAT_W  = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OVF_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  input  logic              rec_is_load_i,
  input  logic              rec_is_store_i,
  input  logic              rec_is_branch_i,
  input  logic [EV_W-1:0]   rec_events_i,
  input  logic [LAT_W-1:0]  rec_latency_i,
  input  logic [DATA_W-1:0] rec_payload_i,
  input  logic              cfg_load_en_i,
  input  logic              cfg_store_en_i,
  input  logic              cfg_branch_en_i,
  input  logic [EV_W-1:0]   cfg_event_mask_i,
  input  logic [LAT_W-1:0]  cfg_min_latency_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_limit_i,
  input  logic              irq_ack_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              irq_o,
  output logic [OVF_W-1:0]  ovf_count_o
);

  import prof_pkg::*;

  op_type_t rec_type;
  op_type_t type_en;
  logic     keep;
  logic     drop;

  assign rec_type = '{is_branch: rec_is_branch_i, is_store: rec_is_store_i, is_load: rec_is_load_i};
  assign type_en  = '{is_branch: cfg_branch_en_i, is_store: cfg_store_en_i, is_load: cfg_load_en_i};

  prof_filter #(.EV_W(EV_W), .LAT_W(LAT_W)) u_filter (
    .valid_i       (rec_valid_i),
    .type_i        (rec_type),
    .events_i      (rec_events_i),
    .latency_i     (rec_latency_i),
    .type_en_i     (type_en),
    .event_mask_i  (cfg_event_mask_i),
    .min_latency_i (cfg_min_latency_i),
    .keep_o        (keep)
  );

  prof_buf_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_writer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .keep_i     (keep),
    .payload_i  (rec_payload_i),
    .base_i     (cfg_base_i),
    .limit_i    (cfg_limit_i),
    .ack_i      (irq_ack_i),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o),
    .irq_o      (irq_o),
    .drop_o     (drop)
  );

  prof_sat_counter #(.W(OVF_W)) u_ovf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (drop),
    .count_o (ovf_count_o)
  );

  initial begin
    assert_ev_width_R2: assert (EV_W >= EV_MIN_W);
  end

  assert_write_has_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(rec_valid_i));

  assert_write_lat_ok_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(rec_latency_i >= cfg_min_latency_i));

  assert_write_type_ok_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(!(cfg_load_en_i || cfg_store_en_i || cfg_branch_en_i) ||
                       (cfg_load_en_i && rec_is_load_i) ||
                       (cfg_store_en_i && rec_is_store_i) ||
                       (cfg_branch_en_i && rec_is_branch_i)));

endmodule

// File: tb/prof_rec_writer_test.sv
module prof_rec_writer_test;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned OVF_W      = 3;
  localparam logic [15:0] FILT_BITS  = 16'h08AA;
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0, is_ld = 1'b0, is_st = 1'b0, is_br = 1'b0;
  logic [15:0] events = '0;
  logic [11:0] latency = '0;
  logic [31:0] payload = '0;
  logic        en_ld = 1'b0, en_st = 1'b0, en_br = 1'b0;
  logic [15:0] ev_mask = '0;
  logic [11:0] min_lat = '0;
  logic [15:0] base = 16'h0100, limit = 16'h01FF;
  logic        ack = 1'b0;
  logic        mem_we, irq;
  logic [15:0] mem_addr;
  logic [31:0] mem_data;
  logic [OVF_W-1:0] ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int unsigned exp_ptr = 0;
  bit exp_irq = 0;
  logic [OVF_W-1:0] exp_ovf = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prof_rec_writer #(.OVF_W(OVF_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rec_valid_i(rec_valid),
    .rec_is_load_i(is_ld), .rec_is_store_i(is_st), .rec_is_branch_i(is_br),
    .rec_events_i(events), .rec_latency_i(latency), .rec_payload_i(payload),
    .cfg_load_en_i(en_ld), .cfg_store_en_i(en_st), .cfg_branch_en_i(en_br),
    .cfg_event_mask_i(ev_mask), .cfg_min_latency_i(min_lat),
    .cfg_base_i(base), .cfg_limit_i(limit), .irq_ack_i(ack),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .irq_o(irq), .ovf_count_o(ovf)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit model_keep(bit ld, bit st, bit br, logic [15:0] ev, logic [11:0] lat);
    bit t_ok = ({en_br, en_st, en_ld} == 3'b000) || (en_ld && ld) || (en_st && st) || (en_br && br);
    bit e_ok = ((ev & ev_mask & FILT_BITS) == (ev_mask & FILT_BITS));
    bit l_ok = lat >= min_lat;
    return t_ok && e_ok && l_ok;
  endfunction

  task automatic send(bit vld, bit ld, bit st, bit br, logic [15:0] ev, logic [11:0] lat,
                      logic [31:0] pl, bit do_ack);
    bit keep = vld && model_keep(ld, st, br, ev, lat);
    @(negedge clk);
    rec_valid = vld; is_ld = ld; is_st = st; is_br = br;
    events = ev; latency = lat; payload = pl; ack = do_ack;
    @(negedge clk);
    rec_valid = 0; ack = 0;
    if (keep && !exp_irq) begin
      chk("R5 write enable", mem_we, 1);
      chk("R5 address", mem_addr, base + exp_ptr[15:0]);
      chk("R5 data", mem_data, pl);
      if (base + exp_ptr[15:0] == limit) exp_irq = 1;
      exp_ptr++;
    end else if (keep) begin
      chk("R7 no write while pending", mem_we, 0);
      if (exp_ovf != OVF_MAX) exp_ovf++;
    end else begin
      chk("R4 discarded, no write", mem_we, 0);
    end
    if (do_ack) begin
      exp_irq = 0;
      exp_ptr = 0;
    end
    chk(do_ack ? "R8 irq after ack" : "R6 irq level", irq, exp_irq);
    chk("R7 overflow count", ovf, exp_ovf);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 reset we", mem_we, 0);
    chk("R9 reset irq", irq, 0);
    chk("R9 reset ovf", ovf, 0);
    rst_n = 1;
    send(1, 1, 0, 0, 0, 5, 32'hA000_0000, 0); // first write at base (R9)
  endtask

  task automatic t_type();
    send(1, 0, 0, 0, 0, 1, 32'h1001, 0);      // R1 no flags, no enables
    send(1, 0, 1, 0, 0, 1, 32'h1002, 0);
    en_ld = 1;
    send(1, 0, 1, 0, 0, 1, 32'h1003, 0);      // R1 store blocked
    send(1, 1, 0, 0, 0, 1, 32'h1004, 0);
    en_br = 1;
    send(1, 0, 0, 1, 0, 1, 32'h1005, 0);      // R1 any enabled type
    send(1, 0, 1, 0, 0, 1, 32'h1006, 0);
    en_ld = 0; en_br = 0;
  endtask

  task automatic t_events();
    ev_mask = 16'h0002;
    send(1, 1, 0, 0, 16'h0002, 1, 32'h2001, 0); // R2 retired
    send(1, 1, 0, 0, 16'h0000, 1, 32'h2002, 0); // R2 speculative drop
    ev_mask = 16'h0882;
    send(1, 1, 0, 0, 16'h0882, 1, 32'h2003, 0);
    send(1, 1, 0, 0, 16'h0802, 1, 32'h2004, 0); // R2 mispredict missing
    send(1, 1, 0, 0, 16'hFFFF, 1, 32'h2005, 0);
    ev_mask = 16'h7001;                          // R2 unfilterable bits ignored
    send(1, 1, 0, 0, 16'h0000, 1, 32'h2006, 0);
    ev_mask = 16'h0028;
    send(1, 1, 0, 0, 16'h0008, 1, 32'h2007, 0); // R2 TLB refill missing
    ev_mask = 0;
  endtask

  task automatic t_latency();
    min_lat = 50;
    send(1, 1, 0, 0, 0, 49, 32'h3001, 0);       // R3 below
    send(1, 1, 0, 0, 0, 50, 32'h3002, 0);       // R3 equal
    send(1, 1, 0, 0, 0, 51, 32'h3003, 0);
    min_lat = 0;
    send(1, 1, 0, 0, 0, 0, 32'h3004, 0);
  endtask

  task automatic t_fill_overflow();
    send(0, 0, 0, 0, 0, 0, 0, 1);               // R8 drain pointer
    limit = base + 16'd3;
    for (int i = 0; i < 4; i++) send(1, 0, 1, 0, 0, 7, 32'h4000 + i, 0); // R6
    for (int i = 0; i < 9; i++) send(1, 0, 1, 0, 0, 7, 32'h5000 + i, 0); // R7 saturate
    min_lat = 100;
    send(1, 0, 1, 0, 0, 7, 32'h5100, 0);        // R4 while pending
    min_lat = 0;
    send(1, 0, 1, 0, 0, 7, 32'h5200, 1);        // R8 record in ack cycle dropped
    send(1, 0, 1, 0, 0, 7, 32'h5300, 0);        // R8 restart at base
    send(1, 0, 1, 0, 0, 7, 32'h5301, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_type();
    t_events();
    t_latency();
    t_fill_overflow();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule